// File: doc/BRIEF.md
# Lockable Tree Pseudo-LRU Victim Selector

This block holds the replacement state for the sets of an 8-way set-associative cache. For every set it keeps a 7-bit binary-tree pseudo-LRU vector and three 8-bit masks: a valid bit for each way, an instruction-lock bit for each way and a data-lock bit for each way. The cache controller presents a set index and a way together with an operation code. The block returns the victim way for the addressed set, or a flag when that set has no usable victim. The block reports the current masks and tree bits of the addressed set back through the same index. It does not hold tags or data.

A lock outlives invalidation. A store-type invalidation clears a locked way's valid bit, and the lock stays. The stale way stays pinned and is never offered as a victim. A later write of modified data makes it valid again. Three flash inputs act on every set in one clock. One clears only the instruction locks, one clears only the data locks, and one clears all valid bits and both kinds of lock.

Top module: `lock_plru`

## Requirements
- R1: After reset every set has zero tree bits, zero valid bits and zero locks, so the reported victim is way 0 and the no-victim flag is low.
- R2: Operations READ (op 0), WRITE (op 1), INVAL (op 2) and ALLOC (op 6) on way w steer the path toward w away from it. Tree bit 0 becomes the inverse of w[2]. Bit 1+w[2] becomes the inverse of w[1]. Bit 3+w[2:1] becomes the inverse of w[0]. The other tree bits, and the tree on the lock operations (3, 4, 5) and on op 7, stay unchanged.
- R3: When a set has a way that is both invalid and unlocked, the victim is the lowest-numbered such way.
- R4: Otherwise the victim follows the tree walk, where 0 means the lower half. Bit 0 picks ways 0-3 or 4-7. Bit 1 or bit 2 then picks a pair. Bits 3-6 pick within pairs 0-1, 2-3, 4-5 and 6-7.
- R5: A tree decision that leads into a subtree whose ways are all locked is reversed, so the victim is never a locked way. A way counts as locked when either of its lock bits is set.
- R6: When all eight ways of a set are locked, the no-victim flag is high and ALLOC changes neither valid bits nor tree bits.
- R7: INVAL clears the way's valid bit and keeps both of its lock bits.
- R8: WRITE sets the way's valid bit and keeps its locks.
- R9: LOCK_I (op 3) sets the instruction lock, LOCK_D (op 4) sets the data lock, and UNLOCK (op 5) clears both locks of that way.
- R10: Flash instruction-lock clear zeroes all instruction locks and keeps data locks. Flash data-lock clear does the reverse.
- R11: Flash invalidate zeroes all valid and lock bits in all sets and keeps the tree bits.
- R12: In a cycle with any flash input high, the per-line operation is dropped.
- R13: An operation changes only the set it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Per-line operation strobe |
| acc_set | input | SW | Set index for operation and readback |
| acc_way | input | 3 | Target way (ignored by ALLOC) |
| acc_op | input | 3 | Operation code |
| fl_inv | input | 1 | Flash invalidate of all sets |
| fl_clr_i | input | 1 | Flash clear of instruction locks |
| fl_clr_d | input | 1 | Flash clear of data locks |
| vic_way | output | 3 | Victim way for acc_set |
| vic_none | output | 1 | All ways of acc_set locked |
| q_valid | output | 8 | Valid mask of acc_set |
| q_ilock | output | 8 | Instruction-lock mask of acc_set |
| q_dlock | output | 8 | Data-lock mask of acc_set |
| q_plru | output | 7 | Tree bits of acc_set |

## Verification
The bench builds the block with SETS=2. Two sets are enough to show that an operation on one set leaves the other alone, and they keep every walk short. With only eight ways, the bench can visit every way under each tree-updating operation. It also reaches every one of the 256 lock masks, with the tree in a varied state each time, so the lock override is checked at every tree node. This includes the fully locked mask.

// File: rtl/lock_plru.sv
module lock_plru #(
  parameter int SETS = 16,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic [SW-1:0] acc_set,
  input  logic [2:0]    acc_way,
  input  logic [2:0]    acc_op,
  input  logic          fl_inv,
  input  logic          fl_clr_i,
  input  logic          fl_clr_d,
  output logic [2:0]    vic_way,
  output logic          vic_none,
  output logic [7:0]    q_valid,
  output logic [7:0]    q_ilock,
  output logic [7:0]    q_dlock,
  output logic [6:0]    q_plru
);
  localparam logic [2:0] OP_READ = 3'd0, OP_WRITE = 3'd1, OP_INVAL = 3'd2,
                         OP_LOCKI = 3'd3, OP_LOCKD = 3'd4, OP_UNLOCK = 3'd5,
                         OP_ALLOC = 3'd6;

  logic [6:0] plru [SETS];
  logic [7:0] vld [SETS];
  logic [7:0] il [SETS];
  logic [7:0] dl [SETS];

  assign q_plru  = plru[acc_set];
  assign q_valid = vld[acc_set];
  assign q_ilock = il[acc_set];
  assign q_dlock = dl[acc_set];

  logic [7:0] avail, free;
  logic [1:0] half;
  logic [3:0] quad;
  logic       b0, b1, b2, b1r, b2r;
  logic [2:0] fway;

  assign avail    = ~(q_ilock | q_dlock);
  assign free     = avail & ~q_valid;
  assign half     = {|avail[7:4], |avail[3:0]};
  assign quad     = {|avail[7:6], |avail[5:4], |avail[3:2], |avail[1:0]};
  assign vic_none = ~|avail;

  always_comb begin
    fway = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (free[i]) fway = 3'(i);
    b0  = q_plru[0] ^ ~half[q_plru[0]];
    b1r = q_plru[1 + int'(b0)];
    b1  = b1r ^ ~quad[{b0, b1r}];
    b2r = q_plru[3 + int'({b0, b1})];
    b2  = b2r ^ ~avail[{b0, b1, b2r}];
  end

  assign vic_way = (|free) ? fway : {b0, b1, b2};

  function automatic logic [6:0] touch(input logic [6:0] p, input logic [2:0] w);
    logic [6:0] r;
    r = p;
    r[0] = ~w[2];
    r[1 + int'(w[2])] = ~w[1];
    r[3 + int'(w[2:1])] = ~w[0];
    return r;
  endfunction

  wire flash = fl_inv | fl_clr_i | fl_clr_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        plru[s] <= '0;
        vld[s]  <= '0;
        il[s]   <= '0;
        dl[s]   <= '0;
      end
    end else if (flash) begin
      for (int s = 0; s < SETS; s++) begin
        if (fl_inv) begin
          vld[s] <= '0;
          il[s]  <= '0;
          dl[s]  <= '0;
        end
        if (fl_clr_i) il[s] <= '0;
        if (fl_clr_d) dl[s] <= '0;
      end
    end else if (acc_vld) begin
      case (acc_op)
        OP_READ:   plru[acc_set] <= touch(q_plru, acc_way);
        OP_WRITE: begin
          plru[acc_set] <= touch(q_plru, acc_way);
          vld[acc_set][acc_way] <= 1'b1;
        end
        OP_INVAL: begin
          plru[acc_set] <= touch(q_plru, acc_way);
          vld[acc_set][acc_way] <= 1'b0;
        end
        OP_LOCKI:  il[acc_set][acc_way] <= 1'b1;
        OP_LOCKD:  dl[acc_set][acc_way] <= 1'b1;
        OP_UNLOCK: begin
          il[acc_set][acc_way] <= 1'b0;
          dl[acc_set][acc_way] <= 1'b0;
        end
        OP_ALLOC:
          if (!vic_none) begin
            plru[acc_set] <= touch(q_plru, vic_way);
            vld[acc_set][vic_way] <= 1'b1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lock_plru_chk.sv
module lock_plru_chk #(
  parameter int SETS = 16,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_vld,
  input logic [SW-1:0] acc_set,
  input logic [2:0]    acc_way,
  input logic [2:0]    acc_op,
  input logic          fl_inv,
  input logic          fl_clr_i,
  input logic          fl_clr_d,
  input logic [2:0]    vic_way,
  input logic          vic_none,
  input logic [7:0]    q_valid,
  input logic [7:0]    q_ilock,
  input logic [7:0]    q_dlock,
  input logic [6:0]    q_plru
);
  wire nofl = !(fl_inv || fl_clr_i || fl_clr_d);

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_none |-> !(q_ilock[vic_way] || q_dlock[vic_way])); // R5
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~q_valid & ~(q_ilock | q_dlock))) |-> !q_valid[vic_way]); // R3
  AST_FULL_LOCK_NOALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_none && acc_vld && acc_op == 3'd6 && nofl) |=>
    (acc_set != $past(acc_set)) || (q_valid == $past(q_valid) && q_plru == $past(q_plru))); // R6
  AST_INVAL_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_op == 3'd2 && nofl) |=>
    (acc_set != $past(acc_set)) ||
    (!q_valid[$past(acc_way)] && q_ilock == $past(q_ilock) && q_dlock == $past(q_dlock))); // R7
  AST_WRITE_REVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_op == 3'd1 && nofl) |=>
    (acc_set != $past(acc_set)) ||
    (q_valid[$past(acc_way)] && q_ilock == $past(q_ilock) && q_dlock == $past(q_dlock))); // R8
  AST_FLASH_CLR_I: assert property (@(posedge clk) disable iff (!rst_n)
    fl_clr_i |=> q_ilock == 8'h00); // R10
  AST_FLASH_CLR_D: assert property (@(posedge clk) disable iff (!rst_n)
    fl_clr_d |=> q_dlock == 8'h00); // R10
  AST_FLASH_INV: assert property (@(posedge clk) disable iff (!rst_n)
    fl_inv |=> (q_valid == 8'h00 && q_ilock == 8'h00 && q_dlock == 8'h00)); // R11
endmodule

bind lock_plru lock_plru_chk #(.SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
  .acc_way(acc_way), .acc_op(acc_op), .fl_inv(fl_inv), .fl_clr_i(fl_clr_i),
  .fl_clr_d(fl_clr_d), .vic_way(vic_way), .vic_none(vic_none),
  .q_valid(q_valid), .q_ilock(q_ilock), .q_dlock(q_dlock), .q_plru(q_plru)
);

// File: tb/sim_lock_plru.sv
`timescale 1ns/1ps
module sim_lock_plru;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_vld = 1'b0;
  logic [0:0] acc_set = '0;
  logic [2:0] acc_way = '0, acc_op = '0;
  logic fl_inv = 1'b0, fl_clr_i = 1'b0, fl_clr_d = 1'b0;
  logic [2:0] vic_way;
  logic vic_none;
  logic [7:0] q_valid, q_ilock, q_dlock;
  logic [6:0] q_plru;

  always #2.5 clk = ~clk;

  lock_plru #(.SETS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
    .acc_way(acc_way), .acc_op(acc_op), .fl_inv(fl_inv), .fl_clr_i(fl_clr_i),
    .fl_clr_d(fl_clr_d), .vic_way(vic_way), .vic_none(vic_none),
    .q_valid(q_valid), .q_ilock(q_ilock), .q_dlock(q_dlock), .q_plru(q_plru)
  );

  int n_chk = 0, n_bad = 0;
  logic [6:0] mp [2];
  logic [7:0] mv [2], mi [2], md [2];

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] mvic(int s);
    logic [7:0] a;
    int lo, size, node, dir;
    a = ~(mi[s] | md[s]);
    for (int i = 0; i < 8; i++)
      if (a[i] && !mv[s][i]) return {1'b0, 3'(i)};
    if (a == 8'h00) return 4'b1000;
    lo = 0; size = 8; node = 0;
    for (int l = 0; l < 3; l++) begin
      size = size / 2;
      dir = int'(mp[s][node]);
      if (((a >> (lo + dir * size)) & ((1 << size) - 1)) == 0) dir = 1 - dir;
      lo = lo + dir * size;
      node = 2 * node + 1 + dir;
    end
    return {1'b0, 3'(lo)};
  endfunction

  function automatic logic [6:0] mtouch(logic [6:0] p, int w);
    int lo, size, node, dir;
    lo = 0; size = 8; node = 0;
    for (int l = 0; l < 3; l++) begin
      size = size / 2;
      dir = (w >= lo + size) ? 1 : 0;
      p[node] = (dir == 0);
      lo = lo + dir * size;
      node = 2 * node + 1 + dir;
    end
    return p;
  endfunction

  task automatic doop(int s, int w, int op, bit fi = 0, bit fci = 0, bit fcd = 0, bit v = 1);
    logic [3:0] vc;
    @(negedge clk);
    acc_set = 1'(s); acc_way = 3'(w); acc_op = 3'(op); acc_vld = v;
    fl_inv = fi; fl_clr_i = fci; fl_clr_d = fcd;
    vc = mvic(s);
    if (fi || fci || fcd) begin
      for (int k = 0; k < 2; k++) begin
        if (fi) begin mv[k] = 0; mi[k] = 0; md[k] = 0; end
        if (fci) mi[k] = 0;
        if (fcd) md[k] = 0;
      end
    end else if (v) begin
      case (op)
        0: mp[s] = mtouch(mp[s], w);
        1: begin mp[s] = mtouch(mp[s], w); mv[s][w] = 1; end
        2: begin mp[s] = mtouch(mp[s], w); mv[s][w] = 0; end
        3: mi[s][w] = 1;
        4: md[s][w] = 1;
        5: begin mi[s][w] = 0; md[s][w] = 0; end
        6: if (!vc[3]) begin mp[s] = mtouch(mp[s], int'(vc[2:0])); mv[s][vc[2:0]] = 1; end
        default: ;
      endcase
    end
    @(negedge clk);
    acc_vld = 0; fl_inv = 0; fl_clr_i = 0; fl_clr_d = 0;
  endtask

  task automatic chk_set(int s, string tag);
    logic [3:0] vc;
    acc_set = 1'(s);
    #1;
    vc = mvic(s);
    cmp(tag, "plru", int'(q_plru), int'(mp[s]));
    cmp(tag, "valid", int'(q_valid), int'(mv[s]));
    cmp(tag, "ilock", int'(q_ilock), int'(mi[s]));
    cmp(tag, "dlock", int'(q_dlock), int'(md[s]));
    cmp(tag, "none", int'(vic_none), int'(vc[3]));
    if (!vc[3]) cmp(tag, "victim", int'(vic_way), int'(vc[2:0]));
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    for (int k = 0; k < 2; k++) begin mp[k] = 0; mv[k] = 0; mi[k] = 0; md[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_set(0, "R1"); chk_set(1, "R1");
    cmp("R1", "victim0", int'(vic_way), 0);

    for (int s = 0; s < 2; s++)
      for (int op = 0; op < 8; op++)
        for (int w = 0; w < 8; w++) begin
          doop(s, w, op == 6 ? 7 : op);
          chk_set(s, "R2");
          chk_set(1 - s, "R13");
        end

    doop(0, 0, 0, 1, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      chk_set(0, "R3");
      cmp("R3", "lowest_free", int'(vic_way), k);
      doop(0, 0, 6);
    end
    chk_set(1, "R13");

    lfsr = 8'h5a;
    for (int k = 0; k < 64; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      doop(0, int'(lfsr[2:0]), k % 2);
      chk_set(0, "R4");
    end

    for (int m = 0; m < 256; m++) begin
      doop(0, 0, 0, 0, 1, 1, 0);
      doop(0, m % 8, 0);
      doop(0, (m / 8) % 8, 0);
      for (int w = 0; w < 8; w++)
        if (m[w]) doop(0, w, (w % 2) ? 4 : 3);
      chk_set(0, m == 255 ? "R6" : "R5");
    end
    doop(0, 0, 6);
    chk_set(0, "R6");
    cmp("R6", "none_flag", int'(vic_none), 1);

    doop(0, 0, 0, 0, 1, 1, 0);
    doop(0, 2, 4);
    doop(0, 2, 2);
    chk_set(0, "R7");
    cmp("R7", "stale_lock", int'(q_dlock[2]), 1);
    cmp("R7", "not_victim", int'(vic_way == 3'd2), 0);
    doop(0, 2, 1);
    chk_set(0, "R8");
    cmp("R8", "revalid", int'(q_valid[2]), 1);

    doop(0, 5, 3); doop(0, 5, 4);
    chk_set(0, "R9");
    doop(0, 5, 5);
    chk_set(0, "R9");

    doop(0, 1, 3); doop(0, 3, 3); doop(0, 3, 4); doop(1, 4, 4); doop(1, 6, 3);
    doop(0, 0, 0, 0, 1, 0, 0);
    chk_set(0, "R10"); chk_set(1, "R10");
    doop(0, 0, 0, 0, 0, 1, 0);
    chk_set(0, "R10"); chk_set(1, "R10");

    doop(0, 6, 4, 0, 1, 0, 1);
    chk_set(0, "R12");
    doop(0, 6, 0, 0, 0, 1, 1);
    chk_set(0, "R12");

    doop(1, 7, 3); doop(0, 4, 4);
    doop(0, 0, 0, 1, 0, 0, 0);
    chk_set(0, "R11"); chk_set(1, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule